// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host perform single-word reads and writes on an external asynchronous static RAM. The host raises a request together with a read/write flag, an address and, for writes, a data word. The controller then steps the memory's active-low chip, output and write enables through a timed sequence and raises a one-clock completion pulse. A read also returns a registered data word on that pulse.

Every analog time limit of the memory is turned into a whole number of clock cycles. A package function rounds each limit up from the nanosecond parameters and the clock-frequency parameter. After reset the controller waits out a long power-up interval before it accepts any access. Each write opens with a turnaround cycle. In that cycle write enable is already low and the controller's data driver is still off, so the memory has time to release the shared bus.

Top module: `async_sram_ctl`

## Requirements
- R1: While reset is high and on the first cycle after it, ready is low, all three memory enables are high (inactive) and the data driver enable is low.
- R2: After reset ends, ready stays low and chip enable stays high for at least the power-up cycle count (default 1 ms rounded up to cycles). Ready rises no more than two cycles after that count.
- R3: A request is ignored while ready is low, whether during power-up or during an access in progress. It produces no memory cycle, no done pulse and no change to memory contents.
- R4: A read holds chip enable and output enable low, and write enable high, for exactly the read cycle count. That count is the largest of the rounded address-access time, the output-enable access time and the cycle time (2 at 100 MHz). The data bus is sampled at the end of the last of these cycles.
- R5: A write holds write enable and chip enable low for the turnaround count plus the pulse count (1 + 2 at 100 MHz), with output enable high throughout. The data driver is on for exactly the pulse cycles and presents the host's write word.
- R6: The data driver is never on while output enable is low. It is off in the first cycle that write enable is low, and it turns on only after at least one cycle of write enable low.
- R7: Done is high for exactly one clock after each accepted access. On a read, the read data output changes on that same clock and then holds until the next read completes.
- R8: The memory address equals the host address captured at acceptance, and it is stable on every cycle that chip enable is low.
- R9: A write can be accepted in the cycle that a read's done pulse is high. Its turnaround cycle then separates output enable going high from the driver turning on.
- R10: Write enable is low only while chip enable is low, so the rise of write enable ends every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, taken when ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data |
| host_ready | output | 1 | Idle and able to accept a request |
| host_done | output | 1 | One-clock completion pulse |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data to the bus driver |
| mem_dq_oe | output | 1 | Bus driver enable, active high |
| mem_dq_in | input | DATA_W | Data from the bus |

## Verification
The bench uses a memory model that returns the inverse of the stored word until output enable has been low for a full cycle. A read that samples too early therefore returns a wrong value, while a read with the correct timing returns the stored value. The bench runs isolated reads and isolated writes and compares them against a shadow copy of memory. It also runs a write accepted on the done cycle of a read, which exposes any missing turnaround. Requests raised during power-up and during a busy read are followed by read-backs of the targeted address, which show whether the ignored write leaked into memory. For each access the bench counts enable, driver and address-change cycles, which separates a timing error from a data error.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_RD     = 3'd2,
    ST_WTURN  = 3'd3,
    ST_WPULSE = 3'd4
  } ctl_state_t;

  // Nanoseconds to whole clock cycles, rounded up.
  function automatic int ns_to_cyc(input int ns, input int clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_pwrup.sv
module sram_ctl_pwrup #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  output logic pwr_ok
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      pwr_ok <= 1'b0;
    end else if (!pwr_ok) begin
      if (cnt == CNT_W'(LIMIT - 1)) pwr_ok <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sram_ctl_phase.sv
module sram_ctl_phase #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int CLK_MHZ     = 100,
  parameter int PWRUP_NS    = 1000000,
  parameter int ADDR_ACC_NS = 17,
  parameter int OE_ACC_NS   = 8,
  parameter int WPULSE_NS   = 12,
  parameter int WSETUP_NS   = 8,
  parameter int RELEASE_NS  = 8,
  parameter int CYCLE_NS    = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ready,
  output logic              host_done,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int PWR_CYC  = imax(1, ns_to_cyc(PWRUP_NS, CLK_MHZ));
  localparam int RD_CYC   = imax(1, imax(imax(ns_to_cyc(ADDR_ACC_NS, CLK_MHZ),
                                              ns_to_cyc(OE_ACC_NS, CLK_MHZ)),
                                         ns_to_cyc(CYCLE_NS, CLK_MHZ)));
  localparam int TURN_CYC = imax(1, ns_to_cyc(RELEASE_NS, CLK_MHZ));
  localparam int WP_CYC   = imax(1, imax(imax(ns_to_cyc(WPULSE_NS, CLK_MHZ),
                                              ns_to_cyc(WSETUP_NS, CLK_MHZ)),
                                         ns_to_cyc(CYCLE_NS, CLK_MHZ) - TURN_CYC));
  localparam int PH_MAX   = imax(RD_CYC, imax(TURN_CYC, WP_CYC));
  localparam int PH_W     = imax(1, $clog2(PH_MAX + 1));

  ctl_state_t        state, state_nxt;
  logic              pwr_ok;
  logic              ph_last;
  logic              ph_load;
  logic [PH_W-1:0]   ph_len;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  // Named events for the checks below.
  logic acc_start, rd_finish, wr_finish;
  assign acc_start = (state == ST_IDLE) && host_req;
  assign rd_finish = (state == ST_RD) && ph_last;
  assign wr_finish = (state == ST_WPULSE) && ph_last;

  sram_ctl_pwrup #(.LIMIT(PWR_CYC)) i_pwrup (
    .clk    (clk),
    .rst    (rst),
    .pwr_ok (pwr_ok)
  );

  sram_ctl_phase #(.W(PH_W)) i_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_len),
    .last     (ph_last)
  );

  always_comb begin
    state_nxt = state;
    case (state)
      ST_PWRUP:  if (pwr_ok)    state_nxt = ST_IDLE;
      ST_IDLE:   if (acc_start) state_nxt = host_wr ? ST_WTURN : ST_RD;
      ST_RD:     if (ph_last)   state_nxt = ST_IDLE;
      ST_WTURN:  if (ph_last)   state_nxt = ST_WPULSE;
      ST_WPULSE: if (ph_last)   state_nxt = ST_IDLE;
      default:                  state_nxt = ST_PWRUP;
    endcase
  end

  always_comb begin
    case (state_nxt)
      ST_RD:     ph_len = PH_W'(RD_CYC - 1);
      ST_WTURN:  ph_len = PH_W'(TURN_CYC - 1);
      ST_WPULSE: ph_len = PH_W'(WP_CYC - 1);
      default:   ph_len = '0;
    endcase
  end
  assign ph_load = (state_nxt != state);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PWRUP;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state  <= state_nxt;
      done_q <= rd_finish || wr_finish;
      if (acc_start) begin
        addr_q  <= host_addr;
        wdata_q <= host_wdata;
      end
      if (rd_finish) rdata_q <= mem_dq_in;
    end
  end

  assign host_ready = (state == ST_IDLE);
  assign host_done  = done_q;
  assign host_rdata = rdata_q;
  assign mem_ce_n   = !((state == ST_RD) || (state == ST_WTURN) || (state == ST_WPULSE));
  assign mem_oe_n   = (state != ST_RD);
  assign mem_we_n   = !((state == ST_WTURN) || (state == ST_WPULSE));
  assign mem_dq_oe  = (state == ST_WPULSE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  assert_no_access_before_pwr_R2: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |-> mem_ce_n);

  assert_drive_not_with_oe_R6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_turn_before_drive_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> $past(!mem_we_n));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_we_inside_ce_R10: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  assert_busy_ignores_req_R3: assert property (@(posedge clk) disable iff (rst)
    (!host_ready && host_req && mem_ce_n && !pwr_ok) |=> mem_ce_n);

endmodule

// File: tb/test_async_sram_ctl.sv
module test_async_sram_ctl;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PWR_CYC = 100;   // 1000 ns at 100 MHz timing base
  localparam int RD_CYC = 2;
  localparam int TURN_CYC = 1;
  localparam int WP_CYC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic ready, done, ce_n, oe_n, we_n, dq_oe;
  logic [AW-1:0] maddr;
  logic [DW-1:0] dq_out, dq_in;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  int oe_run = 0;

  always #10 clk = ~clk;

  async_sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(100), .PWRUP_NS(1000)) i_async_sram_ctl (
    .clk(clk), .rst(rst), .host_req(req), .host_wr(wr), .host_addr(addr),
    .host_wdata(wdata), .host_rdata(rdata), .host_ready(ready), .host_done(done),
    .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_addr(maddr),
    .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in)
  );

  // Memory model: wrong data until output enable has been low a full cycle.
  always @(posedge clk) oe_run <= (!ce_n && !oe_n) ? oe_run + 1 : 0;
  assign dq_in = (!ce_n && !oe_n && oe_run >= RD_CYC - 1) ? mem[maddr] : ~mem[maddr];

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (!we_n && !ce_n && dq_oe) begin
      mem[maddr] <= dq_out;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // One access; counts enable and driver cycles until done.
  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit poke, input bit hold_after,
                        output int ce_c, output int oe_c, output int we_c, output int drv_c,
                        output int drv_first, output int addr_bad, output int dones,
                        output logic [DW-1:0] rd);
    ce_c = 0; oe_c = 0; we_c = 0; drv_c = 0; drv_first = 0; addr_bad = 0; dones = 0;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 0 && poke) begin
        req = 1'b1; wr = 1'b1; addr = a ^ 8'h55; wdata = 8'h99;
      end else begin
        req = 1'b0;
      end
      if (!ce_n) ce_c++;
      if (!oe_n) oe_c++;
      if (!we_n) begin
        if (we_c == 0 && dq_oe) drv_first = 1;
        we_c++;
      end
      if (dq_oe) drv_c++;
      if (!ce_n && maddr != a) addr_bad++;
      if (done) begin dones++; break; end
    end
    rd = rdata;
    if (!hold_after) begin
      @(negedge clk);
      if (done) dones++;
      chk(rdata == rd, "R7 rdata held after done", int'(rdata), int'(rd));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!ready, "R1 ready in reset", ready, 0);
    chk(ce_n && oe_n && we_n, "R1 enables inactive", {ce_n, oe_n, we_n}, 7);
    chk(!dq_oe, "R1 driver off", dq_oe, 0);
  endtask

  task automatic t_powerup();
    int n = 0;
    int ce_seen = 0;
    rst = 1'b0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
      req = (n == 10 || n == 50);
      wr = 1'b1; addr = 8'd9; wdata = 8'h00;
      if (!ce_n) ce_seen++;
    end
    req = 1'b0;
    chk(n >= PWR_CYC && n <= PWR_CYC + 2, "R2 power-up wait", n, PWR_CYC);
    chk(ce_seen == 0, "R2 no access during power-up", ce_seen, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input string tag);
    int ce_c, oe_c, we_c, drv_c, drv_f, ab, dn;
    logic [DW-1:0] rd;
    access(1'b0, a, 8'h00, 1'b0, 1'b0, ce_c, oe_c, we_c, drv_c, drv_f, ab, dn, rd);
    chk(rd == shadow[a], {"R4 read data ", tag}, int'(rd), int'(shadow[a]));
    chk(oe_c == RD_CYC && ce_c == RD_CYC, "R4 read enable cycles", oe_c, RD_CYC);
    chk(we_c == 0 && drv_c == 0, "R4 no write strobe or drive in read", we_c + drv_c, 0);
    chk(dn == 1, "R7 single done on read", dn, 1);
    chk(ab == 0, "R8 read address", ab, 0);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ce_c, oe_c, we_c, drv_c, drv_f, ab, dn;
    logic [DW-1:0] rd;
    access(1'b1, a, d, 1'b0, 1'b0, ce_c, oe_c, we_c, drv_c, drv_f, ab, dn, rd);
    shadow[a] = d;
    chk(we_c == TURN_CYC + WP_CYC && ce_c == we_c, "R5 write strobe cycles", we_c, TURN_CYC + WP_CYC);
    chk(oe_c == 0, "R5 oe high in write", oe_c, 0);
    chk(drv_c == WP_CYC, "R5 driver cycles", drv_c, WP_CYC);
    chk(drv_f == 0, "R6 driver off in first strobe cycle", drv_f, 0);
    chk(ab == 0, "R8 write address", ab, 0);
    chk(dn == 1, "R7 single done on write", dn, 1);
  endtask

  task automatic t_busy_ignore();
    int ce_c, oe_c, we_c, drv_c, drv_f, ab, dn;
    logic [DW-1:0] rd;
    access(1'b0, 8'h20, 8'h00, 1'b1, 1'b0, ce_c, oe_c, we_c, drv_c, drv_f, ab, dn, rd);
    chk(dn == 1 && we_c == 0, "R3 busy request no extra cycle", dn + we_c, 1);
    repeat (3) @(negedge clk);
    chk(!done && ce_n, "R3 nothing started after busy request", done + !ce_n, 0);
    t_read(8'h20 ^ 8'h55, "R3 busy target unchanged");
  endtask

  task automatic t_back_to_back();
    int ce_c, oe_c, we_c, drv_c, drv_f, ab, dn;
    logic [DW-1:0] rd;
    access(1'b0, 8'h40, 8'h00, 1'b0, 1'b1, ce_c, oe_c, we_c, drv_c, drv_f, ab, dn, rd);
    chk(ready, "R9 ready on done cycle", ready, 1);
    // Issue the write in the same cycle as the read's done pulse.
    req = 1'b1; wr = 1'b1; addr = 8'h41; wdata = 8'h5A;
    @(negedge clk);
    req = 1'b0;
    chk(!we_n && !dq_oe, "R9 turnaround after read", dq_oe, 0);
    chk(!ce_n && oe_n, "R10 strobe inside chip enable", ce_n, 0);
    @(negedge clk);
    chk(dq_oe && dq_out == 8'h5A, "R5 driven write data", int'(dq_out), 8'h5A);
    for (int i = 0; i < 5 && !done; i++) @(negedge clk);
    shadow[8'h41] = 8'h5A;
    t_read(8'h41, "R9 write after read");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    t_reset();
    t_powerup();
    t_read(8'd9, "R3 powerup request ignored");
    t_read(8'h00, "low address");
    t_read(8'hFF, "high address");
    t_write(8'h12, 8'hA5);
    t_read(8'h12, "after write");
    t_write(8'h12, 8'h00);
    t_read(8'h12, "zero overwrite");
    t_busy_ignore();
    t_back_to_back();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule